// File: doc/BRIEF.md
# Two-Stage Fused-Pair Issue Scheduler

This block is the issue queue of an out-of-order core whose unit of scheduling is a fused pair: a single-cycle head operation together with a dependent tail. Each pair, or a lone operation, takes one queue slot. The queue is split into three issue lanes. Every lane has its own slots, its own select logic and its own issue port. The issue port feeds a register-read stage with two read ports, so an entry names at most two external source tags. A source written by the head of the same pair is resolved before dispatch and is never presented as a source.

Wakeup and select form two pipeline stages. A grant in one cycle frees the slot. In the next cycle the issued entry appears on the lane's issue port, and its destination tag goes out on a wake bus that all lanes watch. Dependents pick up the wake bus at the end of that cycle and can be granted one cycle later. A dependent's grant therefore comes two cycles after its producer's grant. This spacing is acceptable because the tail of each pair hides the second cycle. In each cycle the dispatcher may offer one entry per lane. Dispatch is all-or-nothing, and a flush empties every lane at once.

Top module: `mop_sched`

## Requirements
- R1: After reset, `iss_valid` and `wk_valid` are all zero, and `disp_ready` is high even when every lane offers an entry.
- R2: An entry whose sources are all absent or marked ready at dispatch appears on its lane's issue port in the second cycle after the dispatch cycle and not earlier. It carries its fused flag, its destination and its source tags. An entry with a source not yet ready does not issue.
- R3: When an entry issues with a valid destination, its lane's `wk_valid` is high in the same cycle and `wk_tag` equals the issued destination. A dependent waiting only on that tag issues exactly two cycles after its producer issues, never one.
- R4: An entry with two external sources issues only after both tags have been woken. It issues two cycles after the later wakeup.
- R5: A lane issues at most one entry per cycle. Among its ready entries it picks the one dispatched earliest, whatever slot each occupies.
- R6: The three lanes issue independently in the same cycle, and a wakeup from any lane reaches waiting entries in every lane.
- R7: A source whose tag is on the wake bus in the cycle the entry is dispatched counts as ready.
- R8: A fused pair takes one slot and issues once, with `iss_fused` high.
- R9: `disp_ready` is low when any lane that is offered an entry has no free slot. In that cycle no lane accepts anything. A full lane does not block dispatch that offers entries only to other lanes.
- R10: A flush discards every entry. In the next cycle nothing issues, and discarded entries never issue later, even after their sources are woken.
- R11: A slot is freed in the cycle its entry is granted, so a full lane raises `disp_ready` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all queued entries |
| disp_valid | input | LANES | Entry offered to each lane |
| disp_fused | input | LANES | Offered entry is a fused pair |
| disp_dst_v | input | LANES | Offered entry writes a destination |
| disp_dst | input | LANES*TAG_W | Destination tag per lane |
| disp_s0_v | input | LANES | First source present |
| disp_s0 | input | LANES*TAG_W | First source tag per lane |
| disp_s0_rdy | input | LANES | First source already available |
| disp_s1_v | input | LANES | Second source present |
| disp_s1 | input | LANES*TAG_W | Second source tag per lane |
| disp_s1_rdy | input | LANES | Second source already available |
| disp_ready | output | 1 | All offered entries are accepted this cycle |
| iss_valid | output | LANES | Entry issued on lane |
| iss_fused | output | LANES | Issued entry is a fused pair |
| iss_dst_v | output | LANES | Issued entry writes a destination |
| iss_dst | output | LANES*TAG_W | Issued destination tag |
| iss_s0_v | output | LANES | Issued first source present |
| iss_s0 | output | LANES*TAG_W | Issued first source tag, for register read |
| iss_s1_v | output | LANES | Issued second source present |
| iss_s1 | output | LANES*TAG_W | Issued second source tag, for register read |
| wk_valid | output | LANES | Wakeup broadcast valid per lane |
| wk_tag | output | LANES*TAG_W | Broadcast destination tag per lane |

## Verification
The bench checks the two-cycle spacing between producer and consumer from both sides. A design with a same-cycle bypass would issue a dependent one cycle early, and one that drops the wake bus at dispatch would leave an entry dispatched alongside its producer's broadcast waiting forever. Age order is tested with the younger entry in the lower slot, so a plain index priority picks the wrong entry. The bench also fills a lane to capacity. A design that accepts part of a dispatch, stalls lanes that have room, or holds a granted slot one cycle too long shows a wrong `disp_ready` or a wrong issue. Finally, the bench flushes entries and then wakes their sources, so a design that only hides flushed entries lets them issue later.

// File: rtl/msched_pkg.sv
package msched_pkg;
  // tag width shared by every scheduler module
  localparam int TAG_W = 7;

  typedef logic [TAG_W-1:0] tag_t;

  // one queue slot: a lone op or a fused head/tail pair
  typedef struct packed {
    logic fused;
    logic dst_v;
    tag_t dst;
    logic s0_v;
    tag_t s0;
    logic s1_v;
    tag_t s1;
  } mop_t;
endpackage

// File: rtl/msched_pick.sv
module msched_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] first,
  output logic         any
);
  // isolate the lowest set bit
  assign first = req & (~req + {{(N-1){1'b0}}, 1'b1});
  assign any   = |req;
endmodule

// File: rtl/msched_age.sv
module msched_age #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] live,
  input  logic [N-1:0] rdy,
  output logic [N-1:0] gnt
);
  // blk_q[i][j] set: slot j was written before slot i
  logic [N-1:0] blk_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) blk_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc[i]) blk_q[i] <= live;
        else          blk_q[i] <= blk_q[i] & ~alloc;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      gnt[i] = rdy[i] && ((blk_q[i] & rdy) == '0);
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
endmodule

// File: rtl/msched_lane.sv
module msched_lane
  import msched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WK_N  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  wr_en,
  input  mop_t                  wr_mop,
  input  logic                  wr_s0_rdy,
  input  logic                  wr_s1_rdy,
  input  logic [WK_N-1:0]       wk_v,
  input  logic [WK_N*TAG_W-1:0] wk_tags,
  output logic                  has_free,
  output logic                  gnt_v,
  output mop_t                  gnt_mop
);
  mop_t             ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q, r0_q, r1_q;
  logic [DEPTH-1:0] rdy, gnt, free_oh, alloc_oh, live;

  function automatic logic tag_hit(input tag_t t, input logic [WK_N-1:0] v,
                                   input logic [WK_N*TAG_W-1:0] tags);
    logic h;
    h = 1'b0;
    for (int k = 0; k < WK_N; k++)
      if (v[k] && (tags[k*TAG_W +: TAG_W] == t)) h = 1'b1;
    return h;
  endfunction

  msched_pick #(.N(DEPTH)) u_free (
    .req   (~vld_q),
    .first (free_oh),
    .any   (has_free)
  );

  assign alloc_oh = wr_en ? free_oh : '0;
  assign live     = vld_q & ~gnt;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rdy[i] = vld_q[i] && (!ent_q[i].s0_v || r0_q[i]) && (!ent_q[i].s1_v || r1_q[i]);
  end

  msched_age #(.N(DEPTH)) u_age (
    .clk   (clk),
    .rst   (rst),
    .alloc (alloc_oh),
    .live  (live),
    .rdy   (rdy),
    .gnt   (gnt)
  );

  always_comb begin
    gnt_v   = |gnt;
    gnt_mop = '0;
    for (int i = 0; i < DEPTH; i++)
      if (gnt[i]) gnt_mop = ent_q[i];
  end

  // occupancy
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_oh[i])  vld_q[i] <= 1'b1;
        else if (gnt[i])  vld_q[i] <= 1'b0;
      end
    end
  end

  // slot payload and source readiness, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_oh[i]) begin
        ent_q[i] <= wr_mop;
        r0_q[i]  <= wr_s0_rdy || tag_hit(wr_mop.s0, wk_v, wk_tags);
        r1_q[i]  <= wr_s1_rdy || tag_hit(wr_mop.s1, wk_v, wk_tags);
      end else begin
        r0_q[i]  <= r0_q[i] || tag_hit(ent_q[i].s0, wk_v, wk_tags);
        r1_q[i]  <= r1_q[i] || tag_hit(ent_q[i].s1, wk_v, wk_tags);
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot_chk
    // R11
    slot_freed_chk: assert property (@(posedge clk) disable iff (rst) gnt[i] |=> !vld_q[i]);
  end
endmodule

// File: rtl/mop_sched.sv
module mop_sched
  import msched_pkg::*;
#(
  parameter int LANES      = 3,
  parameter int LANE_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic [LANES-1:0]       disp_valid,
  input  logic [LANES-1:0]       disp_fused,
  input  logic [LANES-1:0]       disp_dst_v,
  input  logic [LANES*TAG_W-1:0] disp_dst,
  input  logic [LANES-1:0]       disp_s0_v,
  input  logic [LANES*TAG_W-1:0] disp_s0,
  input  logic [LANES-1:0]       disp_s0_rdy,
  input  logic [LANES-1:0]       disp_s1_v,
  input  logic [LANES*TAG_W-1:0] disp_s1,
  input  logic [LANES-1:0]       disp_s1_rdy,
  output logic                   disp_ready,
  output logic [LANES-1:0]       iss_valid,
  output logic [LANES-1:0]       iss_fused,
  output logic [LANES-1:0]       iss_dst_v,
  output logic [LANES*TAG_W-1:0] iss_dst,
  output logic [LANES-1:0]       iss_s0_v,
  output logic [LANES*TAG_W-1:0] iss_s0,
  output logic [LANES-1:0]       iss_s1_v,
  output logic [LANES*TAG_W-1:0] iss_s1,
  output logic [LANES-1:0]       wk_valid,
  output logic [LANES*TAG_W-1:0] wk_tag
);
  localparam int WINDOW = LANES * LANE_DEPTH;

  mop_t             wr_mop  [LANES];
  mop_t             gnt_mop [LANES];
  logic [LANES-1:0] lane_free, gnt_v, wr_en;

  // all-or-nothing dispatch
  assign disp_ready = &(~disp_valid | lane_free);
  assign wr_en      = (disp_ready && !flush) ? disp_valid : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_mop[l].fused = disp_fused[l];
    assign wr_mop[l].dst_v = disp_dst_v[l];
    assign wr_mop[l].dst   = disp_dst[l*TAG_W +: TAG_W];
    assign wr_mop[l].s0_v  = disp_s0_v[l];
    assign wr_mop[l].s0    = disp_s0[l*TAG_W +: TAG_W];
    assign wr_mop[l].s1_v  = disp_s1_v[l];
    assign wr_mop[l].s1    = disp_s1[l*TAG_W +: TAG_W];

    msched_lane #(.DEPTH(WINDOW / LANES), .WK_N(LANES)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush),
      .wr_en     (wr_en[l]),
      .wr_mop    (wr_mop[l]),
      .wr_s0_rdy (disp_s0_rdy[l]),
      .wr_s1_rdy (disp_s1_rdy[l]),
      .wk_v      (wk_valid),
      .wk_tags   (wk_tag),
      .has_free  (lane_free[l]),
      .gnt_v     (gnt_v[l]),
      .gnt_mop   (gnt_mop[l])
    );

    // second stage: issue port and wake bus
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        iss_valid[l] <= 1'b0;
        wk_valid[l]  <= 1'b0;
      end else begin
        iss_valid[l] <= gnt_v[l];
        wk_valid[l]  <= gnt_v[l] && gnt_mop[l].dst_v;
      end
    end

    always_ff @(posedge clk) begin
      iss_fused[l]                <= gnt_mop[l].fused;
      iss_dst_v[l]                <= gnt_mop[l].dst_v;
      iss_dst[l*TAG_W +: TAG_W]   <= gnt_mop[l].dst;
      iss_s0_v[l]                 <= gnt_mop[l].s0_v;
      iss_s0[l*TAG_W +: TAG_W]    <= gnt_mop[l].s0;
      iss_s1_v[l]                 <= gnt_mop[l].s1_v;
      iss_s1[l*TAG_W +: TAG_W]    <= gnt_mop[l].s1;
      wk_tag[l*TAG_W +: TAG_W]    <= gnt_mop[l].dst;
    end

    // R3
    wake_with_issue_chk: assert property (@(posedge clk) disable iff (rst)
      wk_valid[l] |-> iss_valid[l] && iss_dst_v[l]);
    // R3
    wake_tag_match_chk: assert property (@(posedge clk) disable iff (rst)
      wk_valid[l] |-> wk_tag[l*TAG_W +: TAG_W] == iss_dst[l*TAG_W +: TAG_W]);
  end

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> iss_valid == '0);
endmodule

// File: tb/mop_sched_tb_top.sv
module mop_sched_tb_top;
  localparam int LANES = 3;
  localparam int DEPTH = 8;
  localparam int TW    = 7;

  logic clk = 1'b0;
  logic rst, flush;
  logic [LANES-1:0]    d_valid, d_fused, d_dst_v, d_s0_v, d_s0_rdy, d_s1_v, d_s1_rdy;
  logic [LANES*TW-1:0] d_dst, d_s0, d_s1;
  logic                disp_ready;
  logic [LANES-1:0]    iss_valid, iss_fused, iss_dst_v, iss_s0_v, iss_s1_v, wk_valid;
  logic [LANES*TW-1:0] iss_dst, iss_s0, iss_s1, wk_tag;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mop_sched #(.LANES(LANES), .LANE_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_valid(d_valid), .disp_fused(d_fused), .disp_dst_v(d_dst_v), .disp_dst(d_dst),
    .disp_s0_v(d_s0_v), .disp_s0(d_s0), .disp_s0_rdy(d_s0_rdy),
    .disp_s1_v(d_s1_v), .disp_s1(d_s1), .disp_s1_rdy(d_s1_rdy),
    .disp_ready(disp_ready),
    .iss_valid(iss_valid), .iss_fused(iss_fused), .iss_dst_v(iss_dst_v), .iss_dst(iss_dst),
    .iss_s0_v(iss_s0_v), .iss_s0(iss_s0), .iss_s1_v(iss_s1_v), .iss_s1(iss_s1),
    .wk_valid(wk_valid), .wk_tag(wk_tag)
  );

  // {lane[14:13], fused[12], s0v[11], s0r[10], s1v[9], s1r[8], expect_issue[7], dst[6:0]}
  // source tags are fixed at 100 and 101 and are never produced
  localparam logic [14:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd3},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 7'd4},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7'd5},
    {2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 7'd6},
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 7'd7},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 7'd8},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'd9},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 7'd10}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr();
    d_valid = '0; d_fused = '0; d_dst_v = '0; d_s0_v = '0; d_s0_rdy = '0;
    d_s1_v = '0; d_s1_rdy = '0; d_dst = '0; d_s0 = '0; d_s1 = '0;
  endtask

  task automatic disp(input int l, input bit fu, input int dst,
                      input bit s0v, input int s0, input bit s0r,
                      input bit s1v, input int s1, input bit s1r);
    d_valid[l] = 1'b1; d_fused[l] = fu; d_dst_v[l] = 1'b1;
    d_dst[l*TW +: TW] = TW'(dst);
    d_s0_v[l] = s0v; d_s0[l*TW +: TW] = TW'(s0); d_s0_rdy[l] = s0r;
    d_s1_v[l] = s1v; d_s1[l*TW +: TW] = TW'(s1); d_s1_rdy[l] = s1r;
  endtask

  function automatic int idst(input int l);
    return int'(iss_dst[l*TW +: TW]);
  endfunction

  task automatic do_flush();
    flush = 1'b1; tick(); flush = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; flush = 1'b0; clr();
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 iss_valid", int'(iss_valid), 0);
    check("R1 wk_valid", int'(wk_valid), 0);
    d_valid = '1; #1;
    check("R1 disp_ready", int'(disp_ready), 1);
    clr();
    tick();

    // vector walk: R2 latency, fields, R8 fused flag
    for (int v = 0; v < 8; v++) begin
      automatic int  ln = int'(VEC[v][14:13]);
      automatic bit  ex = VEC[v][7];
      disp(ln, VEC[v][12], int'(VEC[v][6:0]), VEC[v][11], 100, VEC[v][10],
           VEC[v][9], 101, VEC[v][8]);
      tick();
      clr();
      check("R2 not early", int'(iss_valid[ln]), 0);
      tick();
      check("R2 issue", int'(iss_valid[ln]), int'(ex));
      if (ex) begin
        check("R2 dst", idst(ln), int'(VEC[v][6:0]));
        check("R8 fused", int'(iss_fused[ln]), int'(VEC[v][12]));
        check("R2 src0 tag", int'(iss_s0[ln*TW +: TW]), VEC[v][11] ? 100 : int'(iss_s0[ln*TW +: TW]));
        check("R3 wake tag", int'(wk_tag[ln*TW +: TW]), int'(VEC[v][6:0]));
      end
      do_flush();
      check("R10 after flush", int'(iss_valid), 0);
      tick();
    end

    // R3 / R6 / R7: producer, dependent, and dispatch-time capture
    disp(0, 0, 5, 0, 0, 0, 0, 0, 0);
    disp(1, 0, 6, 1, 5, 0, 0, 0, 0);
    tick(); clr();
    check("R3 quiet", int'(iss_valid), 0);
    tick();
    check("R3 producer issue", int'(iss_valid[0]), 1);
    check("R3 wake valid", int'(wk_valid[0]), 1);
    check("R3 wake tag", int'(wk_tag[0 +: TW]), 5);
    disp(2, 0, 7, 1, 5, 0, 0, 0, 0);
    tick(); clr();
    check("R3 dependent not early", int'(iss_valid[1]), 0);
    tick();
    check("R3 dependent issue", int'(iss_valid[1]), 1);
    check("R7 capture at dispatch", int'(iss_valid[2]), 1);
    check("R6 three lanes dst", idst(1) * 100 + idst(2), 607);
    tick(); tick();

    // R4: two sources woken at different times
    disp(0, 1, 12, 1, 10, 0, 1, 11, 0);
    disp(1, 0, 10, 0, 0, 0, 0, 0, 0);
    tick(); clr();
    tick();
    check("R4 first producer", int'(iss_valid[1]), 1);
    check("R4 wait M2", int'(iss_valid[0]), 0);
    disp(2, 0, 11, 0, 0, 0, 0, 0, 0);
    tick(); clr();
    check("R4 wait M3", int'(iss_valid[0]), 0);
    tick();
    check("R4 wait M4", int'(iss_valid[0]), 0);
    tick();
    check("R4 wait M5", int'(iss_valid[0]), 0);
    tick();
    check("R4 both woken", int'(iss_valid[0]), 1);
    check("R4 dst", idst(0), 12);
    tick();

    // R5: younger entry sits in the lower slot
    disp(0, 0, 50, 0, 0, 0, 0, 0, 0);
    tick(); clr();
    disp(0, 0, 21, 1, 40, 0, 0, 0, 0);
    tick(); clr();
    check("R5 filler", idst(0), 50);
    disp(0, 0, 22, 1, 40, 0, 0, 0, 0);
    disp(1, 0, 40, 0, 0, 0, 0, 0, 0);
    tick(); clr();
    tick();
    check("R5 producer", idst(1), 40);
    tick();
    check("R5 none yet", int'(iss_valid[0]), 0);
    tick();
    check("R5 oldest first", idst(0), 21);
    tick();
    check("R5 then younger", idst(0), 22);
    check("R5 one per lane", int'(iss_valid[0]), 1);
    tick();

    // R9 / R11: fill lane 2
    for (int i = 0; i < DEPTH - 1; i++) begin
      disp(2, 0, 70 + i, 1, 60, 0, 0, 0, 0);
      tick(); clr();
    end
    disp(2, 0, 62, 0, 0, 0, 0, 0, 0);
    tick(); clr();
    disp(2, 0, 80, 1, 60, 0, 0, 0, 0); #1;
    check("R9 full lane stalls", int'(disp_ready), 0);
    tick();
    check("R11 last entry issues", idst(2), 62);
    #1;
    check("R11 slot freed", int'(disp_ready), 1);
    tick(); clr();
    disp(2, 0, 81, 1, 60, 0, 0, 0, 0);
    disp(0, 0, 61, 0, 0, 0, 0, 0, 0); #1;
    check("R9 stall all lanes", int'(disp_ready), 0);
    tick(); clr();
    tick();
    check("R9 nothing accepted", int'(iss_valid[0]), 0);
    disp(0, 0, 63, 0, 0, 0, 0, 0, 0); #1;
    check("R9 other lane free", int'(disp_ready), 1);
    tick(); clr();
    tick();
    check("R9 other lane issues", idst(0), 63);

    // R10: flush, then wake the discarded entries' source
    do_flush();
    d_valid[2] = 1'b1; #1;
    check("R10 lane emptied", int'(disp_ready), 1);
    clr();
    disp(0, 0, 60, 0, 0, 0, 0, 0, 0);
    tick(); clr();
    for (int i = 0; i < 6; i++) begin
      check("R10 discarded stay", int'(iss_valid[2]), 0);
      tick();
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule